// File: doc/BRIEF.md
# Display Memory Window Decoder

This block sits between the host address bus and the display memory. For each host access it decides whether the 20-bit physical address falls into the display aperture picked by a 2-bit map select. If it does, the block produces the offset inside that aperture. That offset is then turned into a memory location in one of four ways: a plain offset, a chained byte-to-plane interleave, a bank-relocated offset, or a bank-relocated offset that wraps at 128 KB.

A monochrome configuration overrides the map select. In its narrow form it maps 32 KB at 0xB0000 and treats the next 32 KB as an empty hole. In its wide form it maps 64 KB at 0xB0000. A read from the hole returns 0xFF, and a write to the hole goes nowhere. Every result is registered, so it appears one clock after the access strobe. The map select, the monochrome controls, the translation mode and the bank are all sampled with that strobe.

Top module: `dmw_decoder`

## Requirements
- R1: Map select 0 decodes 0xA0000–0xBFFFF. In plain mode, offset_o equals address bits [16:0].
- R2: Map select 1 decodes 0xA0000–0xAFFFF. In plain mode, offset_o equals address bits [15:0].
- R3: Map select 2 decodes 0xB0000–0xB7FFF, and map select 3 decodes 0xB8000–0xBFFFF. In plain mode, offset_o equals address bits [14:0] for both.
- R4: An access outside the active window leaves hit_o, hole_o, mem_rd_o and mem_wr_o low, so another device may answer.
- R5: In chained mode (mode_i = 1), plane_o equals window offset bits [1:0] and offset_o equals the window offset shifted right by two. In every other mode, plane_o is 0.
- R6: In banked mode (mode_i = 2), offset_o equals bank_i plus the low 16 bits of the window offset, taken modulo 2^20.
- R7: In wrapping banked mode (mode_i = 3), offset_o equals bank_i plus the low 16 bits of the window offset, taken modulo 2^17.
- R8: With mono_i = 1 and mono_wide_i = 0, the map select is ignored. 0xB0000–0xB7FFF is mapped, and 0xB8000–0xBFFFF is a hole. A hole access sets hit_o and hole_o, never sets mem_rd_o or mem_wr_o, and a read from the hole returns rdata_o = 0xFF.
- R9: With mono_i = 1 and mono_wide_i = 1, 0xB0000–0xBFFFF is mapped with offset bits [15:0], and there is no hole.
- R10: The outputs reflect the access strobed at the previous rising edge. A cycle with neither rd_i nor wr_i gives hit_o = 0 on the following cycle.
- R11: While rst_ni is low, every output is 0.
- R12: A change of map select between two consecutive accesses takes effect on the second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Host physical address |
| map_sel_i | input | 2 | Aperture select |
| mono_i | input | 1 | Monochrome configuration, overrides map_sel_i |
| mono_wide_i | input | 1 | Widens the monochrome window to 64 KB |
| mode_i | input | 2 | Translation: 0 plain, 1 chained, 2 banked, 3 banked with 128 KB wrap |
| bank_i | input | 20 | Bank offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| hit_o | output | 1 | Access claimed (mapped or hole) |
| hole_o | output | 1 | Access fell in an empty hole |
| mem_rd_o | output | 1 | Read to display memory |
| mem_wr_o | output | 1 | Write to display memory |
| plane_o | output | 2 | Plane number in chained mode |
| offset_o | output | 20 | Display memory offset |
| rdata_o | output | 8 | 0xFF for a hole read, else 0 |

## Verification
The bench probes the first and last byte of every aperture and the bytes just outside them. A decoder with an off-by-one base compare would claim a neighbour's address, or it would drop the top of its own window. The chained cases use addresses with non-zero low bits, which exposes a shift or plane swap. The wrapping banked case uses a sum that crosses 128 KB, which tells a missing wrap apart from a correct one. The bank cases also use an address with bit 16 set, which catches a bank add that uses the full 17-bit offset.

Hole reads and writes are checked for the 0xFF return and for the absence of memory strobes. A map-select change between back-to-back accesses catches a design that reacts a cycle late.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  parameter int DMW_ADDR_W = 20;
  parameter int DMW_OFF_W  = 20;
  parameter int DMW_WIN_W  = 17;  // widest aperture
  parameter int DMW_BANK_SPAN_W = 16;  // offset bits added to the bank
  parameter int DMW_LIN4_W = 17;  // wrap width of wrapping banked mode
  parameter int DMW_SLOTS  = 4;
  parameter logic [DMW_ADDR_W-1:0] DMW_MONO_BASE = 20'hB0000;

  typedef enum logic [1:0] {
    XL_PLAIN = 2'd0,
    XL_CHAIN = 2'd1,
    XL_BANK  = 2'd2,
    XL_LIN4  = 2'd3
  } xl_mode_e;

  function automatic int slot_bits(input int s);
    case (s)
      0: return 17;
      1: return 16;
      default: return 15;
    endcase
  endfunction

  function automatic logic [DMW_ADDR_W-1:0] slot_base(input int s);
    case (s)
      0, 1: return 20'hA0000;
      2: return 20'hB0000;
      default: return 20'hB8000;
    endcase
  endfunction
endpackage

// File: rtl/dmw_aperture.sv
module dmw_aperture
  import dmw_pkg::*;
(
  input  logic [DMW_ADDR_W-1:0] addr_i,
  input  logic [1:0]            map_sel_i,
  input  logic                  mono_i,
  input  logic                  mono_wide_i,
  output logic                  in_win_o,
  output logic                  hole_o,
  output logic [DMW_WIN_W-1:0]  win_off_o
);
  localparam int NARROW_W = 15;
  localparam int WIDE_W   = 16;

  logic [DMW_SLOTS-1:0] slot_hit;
  logic [DMW_WIN_W-1:0] slot_off [DMW_SLOTS];

  for (genvar s = 0; s < DMW_SLOTS; s++) begin : g_slot
    localparam int B = slot_bits(s);
    localparam logic [DMW_ADDR_W-1:0] BASE = slot_base(s);
    assign slot_hit[s] = (addr_i[DMW_ADDR_W-1:B] == BASE[DMW_ADDR_W-1:B]);
    assign slot_off[s] = DMW_WIN_W'(addr_i[B-1:0]);
  end

  localparam logic [DMW_ADDR_W-1:0] HOLE_BASE = DMW_MONO_BASE + (DMW_ADDR_W'(1) << NARROW_W);

  logic mono_lo, mono_hi, mono_wide;
  assign mono_lo   = addr_i[DMW_ADDR_W-1:NARROW_W] == DMW_MONO_BASE[DMW_ADDR_W-1:NARROW_W];
  assign mono_hi   = addr_i[DMW_ADDR_W-1:NARROW_W] == HOLE_BASE[DMW_ADDR_W-1:NARROW_W];
  assign mono_wide = addr_i[DMW_ADDR_W-1:WIDE_W] == DMW_MONO_BASE[DMW_ADDR_W-1:WIDE_W];

  always_comb begin
    in_win_o  = 1'b0;
    hole_o    = 1'b0;
    win_off_o = '0;
    if (mono_i) begin
      if (mono_wide_i) begin
        in_win_o  = mono_wide;
        win_off_o = DMW_WIN_W'(addr_i[WIDE_W-1:0]);
      end else begin
        in_win_o  = mono_lo;
        hole_o    = mono_hi;
        win_off_o = DMW_WIN_W'(addr_i[NARROW_W-1:0]);
      end
    end else begin
      in_win_o  = slot_hit[map_sel_i];
      win_off_o = slot_off[map_sel_i];
    end
  end
endmodule

// File: rtl/dmw_xlate.sv
module dmw_xlate
  import dmw_pkg::*;
(
  input  xl_mode_e              mode_i,
  input  logic [DMW_WIN_W-1:0]  win_off_i,
  input  logic [DMW_OFF_W-1:0]  bank_i,
  output logic [1:0]            plane_o,
  output logic [DMW_OFF_W-1:0]  offset_o
);
  localparam logic [DMW_OFF_W-1:0] LIN4_MASK = (DMW_OFF_W'(1) << DMW_LIN4_W) - DMW_OFF_W'(1);

  logic [DMW_OFF_W-1:0] banked;
  assign banked = bank_i + DMW_OFF_W'(win_off_i[DMW_BANK_SPAN_W-1:0]);

  always_comb begin
    plane_o  = 2'd0;
    offset_o = DMW_OFF_W'(win_off_i);
    unique case (mode_i)
      XL_CHAIN: begin
        plane_o  = win_off_i[1:0];
        offset_o = DMW_OFF_W'(win_off_i >> 2);
      end
      XL_BANK:  offset_o = banked;
      XL_LIN4:  offset_o = banked & LIN4_MASK;
      default:  ;
    endcase
  end
endmodule

// File: rtl/dmw_decoder.sv
module dmw_decoder
  import dmw_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DMW_ADDR_W-1:0] addr_i,
  input  logic [1:0]            map_sel_i,
  input  logic                  mono_i,
  input  logic                  mono_wide_i,
  input  logic [1:0]            mode_i,
  input  logic [DMW_OFF_W-1:0]  bank_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  output logic                  hit_o,
  output logic                  hole_o,
  output logic                  mem_rd_o,
  output logic                  mem_wr_o,
  output logic [1:0]            plane_o,
  output logic [DMW_OFF_W-1:0]  offset_o,
  output logic [7:0]            rdata_o
);
  localparam logic [7:0] HOLE_DATA = 8'hFF;
  localparam logic [DMW_OFF_W-1:0] LIN4_SPAN = DMW_OFF_W'(1) << DMW_LIN4_W;

  logic                 in_win, hole, acc;
  logic [DMW_WIN_W-1:0] win_off;
  logic [1:0]           plane_c;
  logic [DMW_OFF_W-1:0] off_c;
  xl_mode_e             mode;

  assign mode = xl_mode_e'(mode_i);
  assign acc  = rd_i | wr_i;

  dmw_aperture u_aperture (
    .addr_i      (addr_i),
    .map_sel_i   (map_sel_i),
    .mono_i      (mono_i),
    .mono_wide_i (mono_wide_i),
    .in_win_o    (in_win),
    .hole_o      (hole),
    .win_off_o   (win_off)
  );

  dmw_xlate u_xlate (
    .mode_i    (mode),
    .win_off_i (win_off),
    .bank_i    (bank_i),
    .plane_o   (plane_c),
    .offset_o  (off_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      hole_o   <= 1'b0;
      mem_rd_o <= 1'b0;
      mem_wr_o <= 1'b0;
      plane_o  <= 2'd0;
      offset_o <= '0;
      rdata_o  <= 8'h00;
    end else begin
      hit_o    <= acc & (in_win | hole);
      hole_o   <= acc & hole;
      mem_rd_o <= rd_i & in_win;
      mem_wr_o <= wr_i & in_win;
      plane_o  <= plane_c;
      offset_o <= off_c;
      rdata_o  <= (rd_i & hole) ? HOLE_DATA : 8'h00;
    end
  end

  assert_outside_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_win && !hole) |=> (!hit_o && !mem_rd_o && !mem_wr_o));

  assert_chain_plane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_win && mode == XL_CHAIN) |=> (plane_o == $past(addr_i[1:0])));

  assert_lin4_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == XL_LIN4) |=> (offset_o < LIN4_SPAN));

  assert_hole_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hole |=> (!mem_wr_o && !mem_rd_o));

  assert_hole_read_ff_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hole) |=> (rdata_o == HOLE_DATA && hit_o));

  assert_idle_no_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> (!hit_o && !hole_o));
endmodule

// File: tb/dmw_decoder_tb.sv
module dmw_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  map_sel = '0;
  logic        mono = 1'b0, mono_wide = 1'b0;
  logic [1:0]  mode = '0;
  logic [19:0] bank = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        hit, hole, mrd, mwr;
  logic [1:0]  plane;
  logic [19:0] off;
  logic [7:0]  rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmw_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .map_sel_i(map_sel),
    .mono_i(mono), .mono_wide_i(mono_wide), .mode_i(mode), .bank_i(bank),
    .rd_i(rd), .wr_i(wr), .hit_o(hit), .hole_o(hole), .mem_rd_o(mrd),
    .mem_wr_o(mwr), .plane_o(plane), .offset_o(off), .rdata_o(rdata)
  );

  typedef struct packed {
    logic [1:0]  map;  logic mono; logic wide; logic [1:0] mode;
    logic rd; logic wr; logic [19:0] bank; logic [19:0] addr;
    logic e_hit; logic e_hole; logic e_rd; logic e_wr;
    logic [1:0] e_plane; logic [19:0] e_off; logic [7:0] e_rdata;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hA0000, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h00000,8'h00},
    '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b1,20'h00000,20'hBFFFF, 1'b1,1'b0,1'b0,1'b1,2'd0,20'h1FFFF,8'h00},
    '{2'd0,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'h9FFFF, 1'b0,1'b0,1'b0,1'b0,2'd0,20'h00000,8'h00},
    '{2'd1,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hAFFFF, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h0FFFF,8'h00},
    '{2'd1,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hB0000, 1'b0,1'b0,1'b0,1'b0,2'd0,20'h00000,8'h00},
    '{2'd2,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hB7FFF, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h07FFF,8'h00},
    '{2'd2,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hB8000, 1'b0,1'b0,1'b0,1'b0,2'd0,20'h00000,8'h00},
    '{2'd3,1'b0,1'b0,2'd0,1'b0,1'b1,20'h00000,20'hB8004, 1'b1,1'b0,1'b0,1'b1,2'd0,20'h00004,8'h00},
    '{2'd3,1'b0,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hB7FFF, 1'b0,1'b0,1'b0,1'b0,2'd0,20'h00000,8'h00},
    '{2'd0,1'b0,1'b0,2'd1,1'b1,1'b0,20'h00000,20'hA0007, 1'b1,1'b0,1'b1,1'b0,2'd3,20'h00001,8'h00},
    '{2'd0,1'b0,1'b0,2'd1,1'b0,1'b1,20'h00000,20'hA1235, 1'b1,1'b0,1'b0,1'b1,2'd1,20'h0048D,8'h00},
    '{2'd1,1'b0,1'b0,2'd2,1'b1,1'b0,20'h10000,20'hA0010, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h10010,8'h00},
    '{2'd0,1'b0,1'b0,2'd2,1'b1,1'b0,20'h20000,20'hBFFFF, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h2FFFF,8'h00},
    '{2'd1,1'b0,1'b0,2'd3,1'b0,1'b1,20'h1F000,20'hA2000, 1'b1,1'b0,1'b0,1'b1,2'd0,20'h01000,8'h00},
    '{2'd1,1'b0,1'b0,2'd3,1'b1,1'b0,20'h10000,20'hA0100, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h10100,8'h00},
    '{2'd0,1'b1,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hB8010, 1'b1,1'b1,1'b0,1'b0,2'd0,20'h00000,8'hFF},
    '{2'd0,1'b1,1'b0,2'd0,1'b0,1'b1,20'h00000,20'hB8010, 1'b1,1'b1,1'b0,1'b0,2'd0,20'h00000,8'h00},
    '{2'd0,1'b1,1'b0,2'd0,1'b1,1'b0,20'h00000,20'hB1234, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h01234,8'h00},
    '{2'd0,1'b1,1'b1,2'd0,1'b1,1'b0,20'h00000,20'hB8010, 1'b1,1'b0,1'b1,1'b0,2'd0,20'h08010,8'h00},
    '{2'd0,1'b1,1'b1,2'd0,1'b1,1'b0,20'h00000,20'hA0000, 1'b0,1'b0,1'b0,1'b0,2'd0,20'h00000,8'h00},
    '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,20'h00000,20'hA0000, 1'b0,1'b0,1'b0,1'b0,2'd0,20'h00000,8'h00}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1: return "R1";
      2: return "R4";
      3, 4: return "R2";
      5, 6, 7, 8: return "R3";
      9, 10: return "R5";
      11, 12: return "R6";
      13, 14: return "R7";
      15, 16, 17: return "R8";
      18, 19: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] m, input logic [19:0] a, input logic r);
    @(negedge clk);
    map_sel = m; mono = 1'b0; mono_wide = 1'b0; mode = 2'd0; bank = '0;
    addr = a; rd = r; wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    addr = 20'hA0000; rd = 1'b1;
    repeat (3) @(negedge clk);
    // R11: outputs stay low in reset despite a strobed hit
    chk("R11", "hit", 32'(hit), 32'd0);
    chk("R11", "rd",  32'(mrd), 32'd0);
    chk("R11", "off", 32'(off), 32'd0);
    chk("R11", "rdata", 32'(rdata), 32'd0);
    rd = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      map_sel = VEC[i].map; mono = VEC[i].mono; mono_wide = VEC[i].wide;
      mode = VEC[i].mode; rd = VEC[i].rd; wr = VEC[i].wr;
      bank = VEC[i].bank; addr = VEC[i].addr;
      @(negedge clk);
      chk(req_of(i), "hit",   32'(hit),   32'(VEC[i].e_hit));
      chk(req_of(i), "hole",  32'(hole),  32'(VEC[i].e_hole));
      chk(req_of(i), "memrd", 32'(mrd),   32'(VEC[i].e_rd));
      chk(req_of(i), "memwr", 32'(mwr),   32'(VEC[i].e_wr));
      chk(req_of(i), "rdata", 32'(rdata), 32'(VEC[i].e_rdata));
      if (VEC[i].e_hit && !VEC[i].e_hole) begin
        chk(req_of(i), "plane",  32'(plane), 32'(VEC[i].e_plane));
        chk(req_of(i), "offset", 32'(off),   32'(VEC[i].e_off));
      end
    end

    // R12: back-to-back accesses, map select changes between them
    access(2'd0, 20'hB8000, 1'b1);
    access(2'd3, 20'hB8000, 1'b1);
    chk("R12", "off_first", 32'(off), 32'h18000);
    @(negedge clk);
    chk("R12", "off_second", 32'(off), 32'h00000);
    chk("R12", "hit_second", 32'(hit), 32'd1);

    // R10: one cycle latency, result is not visible before the edge
    access(2'd1, 20'hB0000, 1'b1);
    @(negedge clk);
    rd = 1'b1; addr = 20'hA0000;
    #1;
    chk("R10", "hit_before_edge", 32'(hit), 32'd0);
    @(negedge clk);
    chk("R10", "hit_after_edge", 32'(hit), 32'd1);
    rd = 1'b0;
    @(negedge clk);
    chk("R10", "hit_idle", 32'(hit), 32'd0);

    finish_run();
  end
endmodule